// File: doc/BRIEF.md
# Conflict-Free Banked Pixel Store

This block is the on-chip working buffer of a parallel deblocking engine. It holds the 4x4 pixel sub-blocks of one 32x32 region together with the neighbouring sub-blocks to its left and above, for luma and both chroma components. The storage is split into 16 single-port banks of 8 sub-block slots each, so it has 128 slots in total. Sixteen filter-side request lanes serve eight filters, two lanes per filter. Each lane names a sub-block by two labels: the vertical-edge group it belongs to and the horizontal-edge group it belongs to. A fixed placement function turns the two labels into a bank and a slot.

The placement keeps every vertical-edge group spread over distinct banks, and every horizontal-edge group likewise. The upstream sequencer filters all vertical edges of a region before any horizontal edge. It can therefore keep all sixteen lanes busy in either pass without two lanes ever meeting in one bank. Filtered results are written back through the same labels, so they land in the slot they were read from. A separate load/unload lane fills the buffer from frame memory and drains it afterwards. It shares the banks with the filter lanes.

If two requesters do reach the same bank in one cycle, the block refuses all of them, because the bank has a single port. A sticky error flag then records the clash, so that no data is silently corrupted.

Top module: `pixbank_store`

## Requirements
- R1: The vertical-edge label is 4 bits (0..15) and the horizontal-edge label is 3 bits (0..7). A sub-block lives in bank (vertical + horizontal) mod 16, in slot equal to its horizontal label.
- R2: The 8 members of one vertical-edge group occupy 8 distinct banks. Groups v and v+8 together cover all 16 banks, so sixteen lanes reading those two groups in one cycle raise no clash.
- R3: The 16 members of one horizontal-edge group occupy all 16 banks, so sixteen lanes accessing one horizontal group in one cycle raise no clash.
- R4: A granted read returns the slot contents on its lane one cycle after the request, with that lane's rvalid high for that one cycle.
- R5: A granted write stores the data at the slot its labels map to. A later read through the same labels returns it, and no other slot changes.
- R6: When two or more requesters (filter lanes or the load lane, reads or writes) map to the same bank in one cycle, none of them is performed. Their writes are dropped, their rvalid stays low, and requesters in other banks are still served.
- R7: conflict_err rises in the cycle after the first clash and stays high until reset.
- R8: The load/unload lane uses the same labels and placement as a filter lane, with the same one-cycle read latency, and it takes part in clash detection.
- R9: During and after a synchronous active-low reset, every rvalid is low, all read data is zero and conflict_err is low. Reset leaves the bank contents unchanged.
- R10: A lane whose rvalid is low presents all-zero read data. This includes lanes that wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| f_req | input | 16 | Per-lane request; lanes 2k and 2k+1 belong to filter k |
| f_we | input | 16 | Per-lane write enable (1 = write, 0 = read) |
| f_vgrp | input | 64 | Per-lane vertical-edge label, 4 bits per lane, lane 0 in the low bits |
| f_hgrp | input | 48 | Per-lane horizontal-edge label, 3 bits per lane |
| f_wdata | input | 2048 | Per-lane write sub-block, 16 pixels of 8 bits |
| f_rvalid | output | 16 | Per-lane read-data valid, one cycle after a granted read |
| f_rdata | output | 2048 | Per-lane read sub-block, zero when not valid |
| ld_req | input | 1 | Load/unload lane request |
| ld_we | input | 1 | Load/unload lane write enable |
| ld_vgrp | input | 4 | Load/unload vertical-edge label |
| ld_hgrp | input | 3 | Load/unload horizontal-edge label |
| ld_wdata | input | 128 | Load sub-block data |
| ld_rvalid | output | 1 | Unload read-data valid |
| ld_rdata | output | 128 | Unload read sub-block, zero when not valid |
| conflict_err | output | 1 | Sticky bank-clash flag |

## Verification
On every cycle, assertions confirm three things. Any two live requesters that share a vertical label but differ in horizontal label land in different banks, and the same holds for requesters with a shared horizontal label. Every rvalid traces back to a read request one cycle earlier. A clash always sets the error flag, which never falls before reset. Only the bench scenarios can show that data survives the round trip: a full load through the unload lane, complete vertical and horizontal passes, write-back landing in the right slot, clashing writes leaving the slot untouched, and reset keeping the stored pixels.

// File: rtl/pxb_pkg.sv
// Package pxb_pkg
// Shared geometry of the banked pixel store. The placement rule assumes
// that the bank count equals two to the power of the vertical label width
// and is twice the filter count.
package pxb_pkg;
    localparam int NUM_FILT_D = 8;   // parallel filters
    localparam int VGRP_W_D   = 4;   // vertical-edge label width
    localparam int HGRP_W_D   = 3;   // horizontal-edge label width
    localparam int PIX_W_D    = 8;   // bits per pixel
    localparam int SUB_PIX_D  = 16;  // pixels per 4x4 sub-block
endpackage

// File: rtl/pxb_addr_map.sv
// Module pxb_addr_map
// Turns each requester's two group labels into a bank number and an
// in-bank slot. Placement: bank = (v + h) mod 2^VGRP_W, slot = h. The
// module assumes HGRP_W <= VGRP_W. Purely combinational.
module pxb_addr_map #(
    parameter int NREQ   = 17,
    parameter int VGRP_W = 4,
    parameter int HGRP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NREQ-1:0]   req,
    input  logic [VGRP_W-1:0] vgrp [NREQ],
    input  logic [HGRP_W-1:0] hgrp [NREQ],
    output logic [VGRP_W-1:0] bank [NREQ],
    output logic [HGRP_W-1:0] slot [NREQ]
);
    // Placement function: modular sum of the labels picks the bank.
    always_comb begin
        for (int i = 0; i < NREQ; i++) begin
            bank[i] = vgrp[i] + VGRP_W'(hgrp[i]);
            slot[i] = hgrp[i];
        end
    end

    // Mapping checks: live requesters in one group never share a bank (R2, R3).
    always_ff @(posedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NREQ; i++) begin
                for (int j = i + 1; j < NREQ; j++) begin
                    if (req[i] && req[j] && vgrp[i] == vgrp[j] && hgrp[i] != hgrp[j])
                        p_vgroup_distinct_r2: assert (bank[i] != bank[j]);
                    if (req[i] && req[j] && hgrp[i] == hgrp[j] && vgrp[i] != vgrp[j])
                        p_hgroup_distinct_r3: assert (bank[i] != bank[j]);
                end
            end
        end
    end
endmodule

// File: rtl/pxb_conflict.sv
// Module pxb_conflict
// Counts the requesters aimed at each bank. A bank with exactly one
// requester is enabled and remembers which requester owns it. A bank with
// two or more is marked clashed, and all of its requesters are refused.
// Combinational.
module pxb_conflict #(
    parameter int NREQ      = 17,
    parameter int NUM_BANKS = 16,
    parameter int BANK_W    = 4,
    parameter int SEL_W     = $clog2(NREQ)
) (
    input  logic [NREQ-1:0]      req,
    input  logic [BANK_W-1:0]    bank [NREQ],
    output logic [NREQ-1:0]      grant,
    output logic [NUM_BANKS-1:0] bank_en,
    output logic [SEL_W-1:0]     bank_sel [NUM_BANKS],
    output logic                 clash
);
    localparam int CNT_W = $clog2(NREQ + 1);

    logic [CNT_W-1:0]     cnt [NUM_BANKS];
    logic [NUM_BANKS-1:0] multi;

    // Per-bank demand count and owner index.
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            cnt[b]      = '0;
            bank_sel[b] = '0;
            for (int i = 0; i < NREQ; i++) begin
                if (req[i] && bank[i] == BANK_W'(b)) begin
                    cnt[b]      = cnt[b] + CNT_W'(1);
                    bank_sel[b] = SEL_W'(i);
                end
            end
            multi[b]   = cnt[b] > CNT_W'(1);
            bank_en[b] = cnt[b] == CNT_W'(1);
        end
    end

    // Grant only requesters whose bank has no competitor.
    always_comb begin
        for (int i = 0; i < NREQ; i++)
            grant[i] = req[i] && !multi[bank[i]];
        clash = |multi;
    end
endmodule

// File: rtl/pxb_sram_bank.sv
// Module pxb_sram_bank
// One single-port bank of SLOTS sub-blocks. A read registers its data on
// the clock edge. A write and a read cannot happen in the same cycle,
// because the port is single. The storage array has no reset, like a
// real SRAM macro.
module pxb_sram_bank #(
    parameter int SLOTS  = 8,
    parameter int DATA_W = 128,
    parameter int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [SLOT_W-1:0] slot,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [SLOTS];

    // Single port: store on write, register the slot contents on read.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[slot] <= wdata;
            else    rdata     <= mem[slot];
        end
    end
endmodule

// File: rtl/pixbank_store.sv
// Module pixbank_store
// Banked store for the sub-blocks of one region and its neighbours, with
// 2*NUM_FILT filter lanes plus one load/unload lane (internal index
// NREQ-1). All requesters pass through the same label-to-bank placement.
// A clash refuses every requester of the clashed bank and sets a sticky
// error flag. Read data appears one cycle after a granted read.
// Assumptions: NUM_BANKS = 2^VGRP_W = 2*NUM_FILT; HGRP_W <= VGRP_W.
module pixbank_store #(
    parameter int NUM_FILT = pxb_pkg::NUM_FILT_D,
    parameter int VGRP_W   = pxb_pkg::VGRP_W_D,
    parameter int HGRP_W   = pxb_pkg::HGRP_W_D,
    parameter int PIX_W    = pxb_pkg::PIX_W_D,
    parameter int SUB_PIX  = pxb_pkg::SUB_PIX_D,
    localparam int NLANE   = 2 * NUM_FILT,
    localparam int DATA_W  = PIX_W * SUB_PIX
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NLANE-1:0]         f_req,
    input  logic [NLANE-1:0]         f_we,
    input  logic [NLANE*VGRP_W-1:0]  f_vgrp,
    input  logic [NLANE*HGRP_W-1:0]  f_hgrp,
    input  logic [NLANE*DATA_W-1:0]  f_wdata,
    output logic [NLANE-1:0]         f_rvalid,
    output logic [NLANE*DATA_W-1:0]  f_rdata,
    input  logic                     ld_req,
    input  logic                     ld_we,
    input  logic [VGRP_W-1:0]        ld_vgrp,
    input  logic [HGRP_W-1:0]        ld_hgrp,
    input  logic [DATA_W-1:0]        ld_wdata,
    output logic                     ld_rvalid,
    output logic [DATA_W-1:0]        ld_rdata,
    output logic                     conflict_err
);
    localparam int NREQ      = NLANE + 1;
    localparam int NUM_BANKS = 1 << VGRP_W;
    localparam int SLOTS     = 1 << HGRP_W;
    localparam int SEL_W     = $clog2(NREQ);

    logic [NREQ-1:0]   req_all, we_all, grant;
    logic [VGRP_W-1:0] vg_all [NREQ];
    logic [HGRP_W-1:0] hg_all [NREQ];
    logic [DATA_W-1:0] wd_all [NREQ];
    logic [VGRP_W-1:0] bank_all [NREQ];
    logic [HGRP_W-1:0] slot_all [NREQ];

    logic [NUM_BANKS-1:0] bank_en, bank_we;
    logic [SEL_W-1:0]     bank_sel  [NUM_BANKS];
    logic [HGRP_W-1:0]    bank_slot [NUM_BANKS];
    logic [DATA_W-1:0]    bank_wd   [NUM_BANKS];
    logic [DATA_W-1:0]    bank_rd   [NUM_BANKS];
    logic                 clash;

    logic [NREQ-1:0]   rv_q;
    logic [VGRP_W-1:0] bank_q [NREQ];
    logic              err_q;
    logic [DATA_W-1:0] rd_lane [NREQ];

    // Gather filter lanes and the load lane into one requester list.
    always_comb begin
        req_all = {ld_req, f_req};
        we_all  = {ld_we, f_we};
        for (int i = 0; i < NLANE; i++) begin
            vg_all[i] = f_vgrp[i*VGRP_W +: VGRP_W];
            hg_all[i] = f_hgrp[i*HGRP_W +: HGRP_W];
            wd_all[i] = f_wdata[i*DATA_W +: DATA_W];
        end
        vg_all[NREQ-1] = ld_vgrp;
        hg_all[NREQ-1] = ld_hgrp;
        wd_all[NREQ-1] = ld_wdata;
    end

    pxb_addr_map #(.NREQ(NREQ), .VGRP_W(VGRP_W), .HGRP_W(HGRP_W)) u_map (
        .clk(clk), .rst_n(rst_n), .req(req_all),
        .vgrp(vg_all), .hgrp(hg_all), .bank(bank_all), .slot(slot_all)
    );

    pxb_conflict #(.NREQ(NREQ), .NUM_BANKS(NUM_BANKS), .BANK_W(VGRP_W), .SEL_W(SEL_W)) u_cfl (
        .req(req_all), .bank(bank_all), .grant(grant),
        .bank_en(bank_en), .bank_sel(bank_sel), .clash(clash)
    );

    // Route the owning requester's command to each bank.
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            bank_we[b]   = we_all[bank_sel[b]];
            bank_slot[b] = slot_all[bank_sel[b]];
            bank_wd[b]   = wd_all[bank_sel[b]];
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        pxb_sram_bank #(.SLOTS(SLOTS), .DATA_W(DATA_W), .SLOT_W(HGRP_W)) u_bank (
            .clk(clk), .en(bank_en[b]), .we(bank_we[b]), .slot(bank_slot[b]),
            .wdata(bank_wd[b]), .rdata(bank_rd[b])
        );
    end

    // Remember which reads were served and from which bank; keep the error sticky.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rv_q  <= '0;
            err_q <= 1'b0;
            for (int i = 0; i < NREQ; i++) bank_q[i] <= '0;
        end else begin
            rv_q  <= grant & ~we_all;
            err_q <= err_q | clash;
            for (int i = 0; i < NREQ; i++) bank_q[i] <= bank_all[i];
        end
    end

    // Return each served read's bank output, zero otherwise.
    always_comb begin
        for (int i = 0; i < NREQ; i++)
            rd_lane[i] = rv_q[i] ? bank_rd[bank_q[i]] : '0;
        for (int i = 0; i < NLANE; i++)
            f_rdata[i*DATA_W +: DATA_W] = rd_lane[i];
        ld_rdata     = rd_lane[NREQ-1];
        f_rvalid     = rv_q[NLANE-1:0];
        ld_rvalid    = rv_q[NREQ-1];
        conflict_err = err_q;
    end

    for (genvar i = 0; i < NLANE; i++) begin : g_lane_chk
        p_rvalid_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
            f_rvalid[i] |-> ($past(f_req[i]) && !$past(f_we[i])));
    end

    p_ld_rvalid_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_rvalid |-> ($past(ld_req) && !$past(ld_we)));

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        conflict_err |=> conflict_err);

    p_clash_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clash |=> conflict_err);
endmodule

// File: tb/pixbank_store_test.sv
// Scoreboard bench: the driver task applies one cycle of requests, updates
// a reference model of the 128 slots and queues the expected outputs. The
// monitor compares them one cycle later.
module pixbank_store_test;
    localparam int NL = 16;
    localparam int NR = 17;
    localparam int DW = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [NL-1:0]    f_req, f_we, f_rvalid;
    logic [NL*4-1:0]  f_vgrp;
    logic [NL*3-1:0]  f_hgrp;
    logic [NL*DW-1:0] f_wdata, f_rdata;
    logic             ld_req, ld_we, ld_rvalid, conflict_err;
    logic [3:0]       ld_vgrp;
    logic [2:0]       ld_hgrp;
    logic [DW-1:0]    ld_wdata, ld_rdata;

    pixbank_store uut (
        .clk(clk), .rst_n(rst_n), .f_req(f_req), .f_we(f_we), .f_vgrp(f_vgrp),
        .f_hgrp(f_hgrp), .f_wdata(f_wdata), .f_rvalid(f_rvalid), .f_rdata(f_rdata),
        .ld_req(ld_req), .ld_we(ld_we), .ld_vgrp(ld_vgrp), .ld_hgrp(ld_hgrp),
        .ld_wdata(ld_wdata), .ld_rvalid(ld_rvalid), .ld_rdata(ld_rdata),
        .conflict_err(conflict_err)
    );

    typedef struct {
        int             due;
        logic [NR-1:0]  vld;
        logic [NR*DW-1:0] dat;
        logic           err;
        string          tag;
    } exp_t;

    exp_t        sb[$];
    logic [DW-1:0] model [128];
    logic        rq [NR];
    logic        wr [NR];
    logic [3:0]  vg [NR];
    logic [2:0]  hg [NR];
    logic [DW-1:0] wdt [NR];
    logic        exp_err = 1'b0;
    int          cyc = 0;
    int          checks = 0;
    int          fails = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [DW-1:0] pat(int v, int h, int s);
        return {8{8'(v * 16 + h), 8'(s)}};
    endfunction

    task automatic clr();
        for (int i = 0; i < NR; i++) begin
            rq[i] = 1'b0; wr[i] = 1'b0; vg[i] = '0; hg[i] = '0; wdt[i] = '0;
        end
    endtask

    task automatic set_lane(int i, logic w, int v, int h, logic [DW-1:0] d);
        rq[i] = 1'b1; wr[i] = w; vg[i] = 4'(v); hg[i] = 3'(h); wdt[i] = d;
    endtask

    task automatic drive();
        for (int i = 0; i < NL; i++) begin
            f_req[i] = rq[i];
            f_we[i]  = wr[i];
            f_vgrp[i*4 +: 4]   = vg[i];
            f_hgrp[i*3 +: 3]   = hg[i];
            f_wdata[i*DW +: DW] = wdt[i];
        end
        ld_req = rq[NR-1]; ld_we = wr[NR-1]; ld_vgrp = vg[NR-1];
        ld_hgrp = hg[NR-1]; ld_wdata = wdt[NR-1];
    endtask

    // Driver: one request cycle, reference model update, expectation queued.
    task automatic step(string tag);
        exp_t e;
        int   cnt [16];
        int   bk;
        @(negedge clk);
        drive();
        for (int b = 0; b < 16; b++) cnt[b] = 0;
        for (int i = 0; i < NR; i++)
            if (rq[i]) cnt[(int'(vg[i]) + int'(hg[i])) % 16]++;   // R1 placement
        e.vld = '0;
        e.dat = '0;
        for (int i = 0; i < NR; i++) begin
            bk = (int'(vg[i]) + int'(hg[i])) % 16;
            if (rq[i] && cnt[bk] == 1) begin
                if (wr[i]) model[{vg[i], hg[i]}] = wdt[i];
                else begin
                    e.vld[i] = 1'b1;
                    e.dat[i*DW +: DW] = model[{vg[i], hg[i]}];
                end
            end
        end
        for (int b = 0; b < 16; b++) if (cnt[b] > 1) exp_err = 1'b1;
        e.err = exp_err;
        e.due = cyc + 1;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare outputs with the queued expectation for this cycle.
    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if ({ld_rvalid, f_rvalid} !== e.vld) begin
                fails++;
                $display("FAIL %s rvalid act=%h exp=%h", e.tag, {ld_rvalid, f_rvalid}, e.vld);
            end
            checks++;
            if ({ld_rdata, f_rdata} !== e.dat) begin
                fails++;
                $display("FAIL %s rdata act=%h exp=%h", e.tag, {ld_rdata, f_rdata}, e.dat);
            end
            checks++;
            if (conflict_err !== e.err) begin
                fails++;
                $display("FAIL %s conflict_err act=%b exp=%b", e.tag, conflict_err, e.err);
            end
        end
    end

    task automatic check_idle_outputs(string tag);
        checks++;
        if (f_rvalid !== '0 || ld_rvalid !== 1'b0 || f_rdata !== '0 ||
            ld_rdata !== '0 || conflict_err !== 1'b0) begin
            fails++;
            $display("FAIL %s reset outputs act=%h/%b/%b exp=0/0/0", tag,
                     f_rvalid, ld_rvalid, conflict_err);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog expired act=running exp=done");
        finish_run();
    end

    initial begin
        clr();
        drive();
        repeat (3) @(negedge clk);
        check_idle_outputs("R9 reset");
        rst_n = 1'b1;

        // R8: fill every slot through the load lane.
        for (int v = 0; v < 16; v++)
            for (int h = 0; h < 8; h++) begin
                clr(); set_lane(16, 1'b1, v, h, pat(v, h, 1)); step("R8 R10 load fill");
            end
        // R1 R4: unload every slot.
        for (int v = 0; v < 16; v++)
            for (int h = 0; h < 8; h++) begin
                clr(); set_lane(16, 1'b0, v, h, '0); step("R1 R4 R8 unload");
            end
        // R2: vertical pass, groups v and v+8 together on all sixteen lanes.
        for (int v = 0; v < 8; v++) begin
            clr();
            for (int h = 0; h < 8; h++) begin
                set_lane(h, 1'b0, v, h, '0); set_lane(8 + h, 1'b0, v + 8, h, '0);
            end
            step("R2 vertical read");
        end
        // R5: vertical write-back, then read again.
        for (int v = 0; v < 8; v++) begin
            clr();
            for (int h = 0; h < 8; h++) begin
                set_lane(h, 1'b1, v, h, pat(v, h, 2));
                set_lane(8 + h, 1'b1, v + 8, h, pat(v + 8, h, 2));
            end
            step("R5 R10 vertical write");
        end
        // R3: horizontal pass reads, write-back, then read back.
        for (int h = 0; h < 8; h++) begin
            clr();
            for (int v = 0; v < 16; v++) set_lane(v, 1'b0, v, h, '0);
            step("R3 horizontal read");
        end
        for (int h = 0; h < 8; h += 2) begin
            clr();
            for (int v = 0; v < 16; v++) set_lane(v, 1'b1, v, h, pat(v, h, 3));
            step("R3 R5 horizontal write");
        end
        for (int h = 0; h < 8; h++) begin
            clr();
            for (int v = 0; v < 16; v++) set_lane(v, 1'b0, 15 - v, h, '0);
            step("R3 R5 horizontal reread");
        end

        // R6: read and write clash in bank 0; lane 2 in bank 8 is still served.
        clr();
        set_lane(0, 1'b0, 0, 0, '0);
        set_lane(1, 1'b1, 15, 1, pat(0, 0, 9));
        set_lane(2, 1'b0, 3, 5, '0);
        step("R6 R7 clash read-write");
        clr(); set_lane(4, 1'b0, 15, 1, '0); step("R6 dropped write");
        // R1: (3,5) and (7,1) share bank 8; (4,5) alone in bank 9.
        clr();
        set_lane(6, 1'b0, 3, 5, '0);
        set_lane(7, 1'b0, 7, 1, '0);
        set_lane(9, 1'b0, 4, 5, '0);
        step("R1 R6 same bank");
        // R8: load lane clashes with a filter lane in bank 0.
        clr();
        set_lane(16, 1'b1, 9, 7, pat(1, 1, 7));
        set_lane(5, 1'b0, 0, 0, '0);
        set_lane(11, 1'b0, 2, 2, '0);
        step("R8 R6 load clash");
        clr(); set_lane(12, 1'b0, 9, 7, '0); set_lane(16, 1'b0, 0, 0, '0);
        step("R8 R6 load dropped write");
        // R7: error stays high through idle cycles.
        for (int k = 0; k < 3; k++) begin
            clr(); step("R7 sticky idle");
        end

        // R9 R7: reset clears the flag but keeps the bank contents.
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        exp_err = 1'b0;
        repeat (2) @(negedge clk);
        check_idle_outputs("R7 R9 reset clears error");
        rst_n = 1'b1;
        clr();
        for (int v = 0; v < 16; v++) set_lane(v, 1'b0, v, 6, '0);
        set_lane(16, 1'b0, 9, 7, '0);
        step("R9 R4 contents kept");
        clr(); step("R9 idle");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule